// File: doc/BRIEF.md
# Power Domain Switch Sequencer

This block turns power on and off for a set of switchable power domains. With the default parameters there are two: a sub-system domain and an audio domain. Software writes one enable bit per domain into a configuration register. For each domain whose enable disagrees with its settled state, a dedicated sequencer runs a multi-cycle power-down or power-up sequence. The sequence drives the domain's power switch, isolation and reset handshake outputs.

A read-only status register reports the settled state of each domain. A status bit flips only when its domain's sequence has fully completed. While a transition runs, the config bit and the status bit therefore differ. Software polls status until it equals config before moving on.

The CPU core domain sits at bit 0 of both registers. It is permanently on and cannot be switched. Each domain is sequenced independently, and the time allowed for its rail to settle comes from a programmable count input.

Top module: `pwr_domain_switch`

## Requirements
- R1: During and right after reset, every domain is powered, and both registers read all ones.
  - Powered means: switch on, isolation released, domain reset released.
  - All busy outputs are 0.
- R2: Bit 0 of both registers always reads 1, whatever is written to it.
  - Writing 0 to bit 0 changes no output.
  - `cpu_pwr_on` is always 1.
- R3: Register bit layout:
  - Bit 1 belongs to the sub domain.
  - Bit 2 belongs to the audio domain.
  - A write with `cfg_we` high at a clock edge is visible on `cfg_rdata` right after that edge.
- R4: Power-down runs in this order, with S = `settle_cycles`:
  - 1 cycle after the write edge, isolation asserts.
  - 1 cycle later, domain reset asserts.
  - 1 cycle later, the switch opens.
  - The switch never opens unless isolation and reset are both asserted.
- R5: Power-up runs in this order:
  - 1 cycle after the write edge, the switch closes.
  - S+2 cycles after that, domain reset releases.
  - 1 cycle later, isolation releases.
  - Isolation never releases while reset is asserted.
- R6: A domain's status bit changes exactly S+5 cycles after the write edge that started its sequence, in both directions. It does not change at any other time.
- R7: `dom_busy[i]` is 1 exactly when the config bit and the status bit of domain i differ.
- R8: The two domains are sequenced independently. Sequences may overlap and may start at different times.
- R9: A config write during a transition does not interrupt the running sequence.
  - When the sequence ends, the opposite sequence starts on the next cycle, provided the config bit then differs from the new status.
  - Otherwise the domain stays settled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | N_DOM+1 | Write data. Bit 0 is ignored, bit 1 is sub, bit 2 is audio |
| settle_cycles | input | SETTLE_W | Rail settle count S used by both sequences |
| cfg_rdata | output | N_DOM+1 | Configuration register contents |
| stat_rdata | output | N_DOM+1 | Settled power state of each domain |
| dom_busy | output | N_DOM | Per-domain transition in progress |
| dom_pwr_sw | output | N_DOM | Power switch closed (domain powered) |
| dom_iso | output | N_DOM | Output isolation asserted |
| dom_rst | output | N_DOM | Domain reset asserted |
| cpu_pwr_on | output | 1 | CPU domain power, fixed at 1 |

## Verification
The bench goes after four kinds of corner case:
- **Settle count of zero.** A design that counted one too few or one too many settle cycles would move status a cycle early or late, and every transition would be flagged.
- **Rewrites mid-sequence.** The bench rewrites a config bit in the middle of a sequence, including flipping it back to the original value. A sequencer that aborted or reversed midway would show a premature status change or a switch opening without isolation.
- **Overlapping domains.** Transitions on both domains overlap, which exposes any shared counter or crossed wiring.
- **Writes of 0 to the CPU bit.** These would show up as a cleared bit 0 if the fixed-on bit were writable.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [3:0] {
    ST_ON,
    ST_DN_ISO,
    ST_DN_RST,
    ST_DN_SW,
    ST_DN_WAIT,
    ST_OFF,
    ST_UP_SW,
    ST_UP_WAIT,
    ST_UP_RST,
    ST_UP_ISO
  } dom_state_e;

endpackage

// File: rtl/pwr_cfg_reg.sv
module pwr_cfg_reg #(
  parameter int N_DOM = 2,
  localparam int NREG = N_DOM + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [NREG-1:0] wdata,
  output logic [NREG-1:0] cfg_q
);

  // Bit 0 is the fixed-on CPU domain: forced high on every write
  localparam logic [NREG-1:0] FIXED_MASK = {{N_DOM{1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_q <= '1;
    else if (we) cfg_q <= wdata | FIXED_MASK;
  end

  AST_CFG_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> cfg_q[NREG-1:1] == $past(wdata[NREG-1:1])); // R3

endmodule

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq
  import pwr_seq_pkg::*;
#(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_en,
  input  logic [SETTLE_W-1:0] settle,
  output logic                sw_on,
  output logic                iso_on,
  output logic                rst_on,
  output logic                stat
);

  dom_state_e          state, nxt;
  logic [SETTLE_W-1:0] cnt;
  logic                waiting;

  assign waiting = (state == ST_DN_WAIT) || (state == ST_UP_WAIT);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_ON:      if (!cfg_en) nxt = ST_DN_ISO;
      ST_DN_ISO:  nxt = ST_DN_RST;
      ST_DN_RST:  nxt = ST_DN_SW;
      ST_DN_SW:   nxt = ST_DN_WAIT;
      ST_DN_WAIT: if (cnt == '0) nxt = ST_OFF;
      ST_OFF:     if (cfg_en) nxt = ST_UP_SW;
      ST_UP_SW:   nxt = ST_UP_WAIT;
      ST_UP_WAIT: if (cnt == '0) nxt = ST_UP_RST;
      ST_UP_RST:  nxt = ST_UP_ISO;
      ST_UP_ISO:  nxt = ST_ON;
      default:    nxt = ST_ON;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_ON;
      cnt   <= '0;
    end else begin
      state <= nxt;
      if (state == ST_DN_SW || state == ST_UP_SW) cnt <= settle;
      else if (waiting && cnt != '0)              cnt <= cnt - 1'b1;
    end
  end

  always_comb begin
    sw_on  = !(state inside {ST_DN_SW, ST_DN_WAIT, ST_OFF});
    iso_on = !(state inside {ST_ON, ST_UP_ISO});
    rst_on = state inside {ST_DN_RST, ST_DN_SW, ST_DN_WAIT, ST_OFF, ST_UP_SW, ST_UP_WAIT};
    stat   = state inside {ST_ON, ST_DN_ISO, ST_DN_RST, ST_DN_SW, ST_DN_WAIT};
  end

  AST_SW_OPEN_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_on |-> (iso_on && rst_on)); // R4

  AST_ISO_DROP_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iso_on) |-> !rst_on); // R5

  AST_STAT_RISE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat) |-> $past(sw_on && !iso_on && !rst_on)); // R6

  AST_STAT_FALL_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat) |-> ($past(!sw_on) && !sw_on)); // R6

endmodule

// File: rtl/pwr_domain_switch.sv
module pwr_domain_switch #(
  parameter int N_DOM    = 2,
  parameter int SETTLE_W = 8,
  localparam int NREG    = N_DOM + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [NREG-1:0]     cfg_wdata,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic [NREG-1:0]     cfg_rdata,
  output logic [NREG-1:0]     stat_rdata,
  output logic [N_DOM-1:0]    dom_busy,
  output logic [N_DOM-1:0]    dom_pwr_sw,
  output logic [N_DOM-1:0]    dom_iso,
  output logic [N_DOM-1:0]    dom_rst,
  output logic                cpu_pwr_on
);

  logic [N_DOM-1:0] stat_bits;

  pwr_cfg_reg #(.N_DOM(N_DOM)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg_q (cfg_rdata)
  );

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    pwr_dom_seq #(.SETTLE_W(SETTLE_W)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .cfg_en (cfg_rdata[d+1]),
      .settle (settle_cycles),
      .sw_on  (dom_pwr_sw[d]),
      .iso_on (dom_iso[d]),
      .rst_on (dom_rst[d]),
      .stat   (stat_bits[d])
    );

    assign dom_busy[d] = cfg_rdata[d+1] ^ stat_bits[d];

    AST_STAT_MOVES_POWERED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_bits[d] != $past(stat_bits[d])) |-> (stat_bits[d] == dom_pwr_sw[d])); // R6
  end

  assign stat_rdata = {stat_bits, 1'b1};
  assign cpu_pwr_on = 1'b1;

endmodule

// File: tb/pwr_domain_switch_tb.sv
`timescale 1ns/1ps
module pwr_domain_switch_tb;

  localparam int ND = 2;
  localparam int NR = ND + 1;
  localparam int SW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [NR-1:0] cfg_wdata = '0;
  logic [SW-1:0] settle_cycles = 8'd2;
  logic [NR-1:0] cfg_rdata, stat_rdata;
  logic [ND-1:0] dom_busy, dom_pwr_sw, dom_iso, dom_rst;
  logic          cpu_pwr_on;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Reference model: per-domain config, status, remaining cycles, direction, settle
  bit m_cfg [ND];
  bit m_stat[ND];
  int m_cnt [ND];
  bit m_up  [ND];
  int m_s   [ND];

  always #5 clk = ~clk;

  pwr_domain_switch #(.N_DOM(ND), .SETTLE_W(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .settle_cycles(settle_cycles), .cfg_rdata(cfg_rdata), .stat_rdata(stat_rdata),
    .dom_busy(dom_busy), .dom_pwr_sw(dom_pwr_sw), .dom_iso(dom_iso),
    .dom_rst(dom_rst), .cpu_pwr_on(cpu_pwr_on)
  );

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  function automatic void model_reset();
    for (int d = 0; d < ND; d++) begin
      m_cfg[d] = 1'b1; m_stat[d] = 1'b1; m_cnt[d] = 0; m_up[d] = 1'b0; m_s[d] = 0;
    end
  endfunction

  // Effect of one clock edge with the pre-edge inputs
  function automatic void model_edge(bit we, logic [NR-1:0] wd, int s);
    for (int d = 0; d < ND; d++) begin
      if (m_cnt[d] > 0) begin
        m_cnt[d]--;
        if (m_cnt[d] == 0) m_stat[d] = m_up[d];
      end else if (m_cfg[d] != m_stat[d]) begin
        m_up[d] = m_cfg[d]; m_s[d] = s; m_cnt[d] = 4 + s;
      end
      if (we) m_cfg[d] = wd[d+1];
    end
  endfunction

  function automatic bit all_idle();
    for (int d = 0; d < ND; d++)
      if (m_cnt[d] != 0 || m_cfg[d] != m_stat[d]) return 1'b0;
    return 1'b1;
  endfunction

  // Compare every output with the model (called away from the active edge)
  task automatic check_all(string seg);
    bit esw, eiso, erst;
    int p;
    chk("R2", {seg, " cfg bit0"}, int'(cfg_rdata[0]), 1);
    chk("R2", {seg, " stat bit0"}, int'(stat_rdata[0]), 1);
    chk("R2", {seg, " cpu_pwr_on"}, int'(cpu_pwr_on), 1);
    for (int d = 0; d < ND; d++) begin
      if (m_cnt[d] == 0) begin
        esw = m_stat[d]; eiso = !m_stat[d]; erst = !m_stat[d];
      end else begin
        p = 4 + m_s[d] - m_cnt[d];
        if (!m_up[d]) begin   // R4 order
          eiso = 1'b1; erst = (p >= 1); esw = !(p >= 2);
        end else begin        // R5 order
          esw = 1'b1; erst = !(p >= 2 + m_s[d]); eiso = !(p >= 3 + m_s[d]);
        end
      end
      chk("R3", $sformatf("%s cfg dom%0d", seg, d), int'(cfg_rdata[d+1]), int'(m_cfg[d]));
      chk("R6", $sformatf("%s stat dom%0d", seg, d), int'(stat_rdata[d+1]), int'(m_stat[d]));
      chk("R7", $sformatf("%s busy dom%0d", seg, d), int'(dom_busy[d]), int'(m_cfg[d] != m_stat[d]));
      chk("R4 R5", $sformatf("%s switch dom%0d", seg, d), int'(dom_pwr_sw[d]), int'(esw));
      chk("R4 R5", $sformatf("%s iso dom%0d", seg, d), int'(dom_iso[d]), int'(eiso));
      chk("R4 R5", $sformatf("%s reset dom%0d", seg, d), int'(dom_rst[d]), int'(erst));
    end
  endtask

  task automatic step(bit we, logic [NR-1:0] wd, string seg);
    cfg_we = we; cfg_wdata = wd;
    @(posedge clk);
    model_edge(we, wd, int'(settle_cycles));
    @(negedge clk);
    cfg_we = 1'b0;
    check_all(seg);
  endtask

  task automatic idle(int n, string seg);
    for (int i = 0; i < n; i++) step(1'b0, '0, seg);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R1 reset");
    rst_n = 1'b1;
    idle(2, "R1 idle");

    // R4/R6 power down sub domain, bit0 written 0 (R2)
    settle_cycles = 8'd2;
    step(1'b1, 3'b100, "R4 down sub");
    idle(10, "R4 down sub");
    // R5 power up again
    step(1'b1, 3'b111, "R5 up sub");
    idle(10, "R5 up sub");

    // R6 with zero settle count
    settle_cycles = 8'd0;
    step(1'b1, 3'b001, "R6 zero settle");
    idle(8, "R6 zero settle");
    step(1'b1, 3'b111, "R6 zero settle");
    idle(8, "R6 zero settle");

    // R9 rewrite back mid-sequence: finish down, then power up again
    settle_cycles = 8'd3;
    step(1'b1, 3'b011, "R9 rewrite");
    idle(2, "R9 rewrite");
    step(1'b1, 3'b111, "R9 rewrite");
    idle(20, "R9 rewrite");
    // R9 flip twice mid-sequence: ends settled off
    step(1'b1, 3'b011, "R9 double");
    step(1'b1, 3'b111, "R9 double");
    step(1'b1, 3'b011, "R9 double");
    idle(20, "R9 double");

    // R8 overlapping, staggered domains
    step(1'b1, 3'b101, "R8 overlap");
    idle(2, "R8 overlap");
    step(1'b1, 3'b011, "R8 overlap");
    idle(20, "R8 overlap");
    step(1'b1, 3'b111, "R8 overlap");
    idle(15, "R8 overlap");

    // Random traffic: R3 R6 R7 R8 R9
    for (int i = 0; i < 1500; i++) begin
      if (all_idle() && ($urandom % 4 == 0)) settle_cycles = SW'($urandom % 6);
      if ($urandom % 5 == 0) step(1'b1, NR'($urandom), "random");
      else                   step(1'b0, '0, "random");
    end
    idle(20, "random drain");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired: got 0 expected 1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule